// File: doc/BRIEF.md
# T=0 Command Header Engine

This block sits on the card side of a T=0 smart-card link, between a byte-level UART and a host that answers commands. Out of reset it listens to the reader and gathers the five command header bytes (class, instruction, two parameters, length) one state per byte. Once the length byte is in, it hands the whole header to the host as a single 40-bit record and turns the line around: the receiver is switched off and the transmitter on.

While the host works out its answer, a counter watches the idle line. Each time half of the programmed waiting time (in clock cycles) passes with nothing sent, the block sends the null procedure byte 0x60, which tells the reader to keep waiting. When the host supplies a procedure byte together with a direction, that byte goes out instead. Once the UART accepts it, the block moves to a data phase. In the receive phase, reader bytes are forwarded to the host. In the transmit phase, bytes are read from a host buffer by a running index. A host end-of-command pulse returns the block to header collection.

Top module: `t0_cmd_engine`

## Requirements
- R1: After reset the block collects headers: `rx_en`=1, `tx_en`=0, `tx_valid`=0, `hdr_valid`=0 and `pb_ready`=0.
- R2: Five accepted bytes are stored in arrival order, and `hdr_data` = {byte0, byte1, byte2, byte3, byte4}, with the first byte in bits 39:32. `hdr_valid` is a one-cycle pulse in the cycle after the fifth byte is accepted.
- R3: When the header is delivered, the receiver is disabled and the transmitter is enabled (`rx_en`=0, `tx_en`=1). The two enables are never high together.
- R4: While the block is waiting for the host with an idle transmit slot, `tx_valid` rises with byte 0x60 exactly `wait_clks`/2 cycles after the header pulse. The null byte repeats for as long as the host gives no procedure byte.
- R5: A procedure byte taken on `pb_valid`&&`pb_ready` is transmitted. If it falls in the same cycle as a due null byte, the procedure byte wins and no 0x60 is sent. When the UART accepts it, the block enters receive-data (`pb_dir`=0) or transmit-data (`pb_dir`=1).
- R6: In receive-data, each accepted byte appears on `rx_fwd_byte` with a one-cycle `rx_fwd_valid` pulse in the following cycle. The block stays in this state with `rx_en`=1 and `tx_en`=0.
- R7: In transmit-data, after `txb_load` with `txb_len`=N (N≥1), bytes at indices 0..N-1 are sent in order. `txb_release` pulses in the cycle in which the last byte is accepted. The block then stays in transmit-data and sends nothing more.
- R8: An `end_cmd` pulse returns the block to header collection in the next cycle, with any pending transmit byte dropped.
- R9: A byte offered on `rx_valid` while `rx_en`=0 is ignored. It is neither forwarded nor captured into a later header.
- R10: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` stays high and `tx_byte` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_clks | input | WT_W | Waiting time in clock cycles |
| rx_valid | input | 1 | Byte received by the UART |
| rx_byte | input | 8 | Received byte |
| rx_en | output | 1 | UART receiver enable |
| tx_en | output | 1 | UART transmitter enable |
| tx_valid | output | 1 | Byte offered to the UART transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART transmitter accepts the byte |
| hdr_valid | output | 1 | Header record ready pulse |
| hdr_data | output | 40 | Five header bytes, first byte in the top bits |
| pb_valid | input | 1 | Host offers a procedure byte |
| pb_byte | input | 8 | Procedure byte from the host |
| pb_dir | input | 1 | Data phase after the procedure byte: 0 receive, 1 transmit |
| pb_ready | output | 1 | Procedure byte can be taken |
| rx_fwd_valid | output | 1 | Forwarded data byte valid |
| rx_fwd_byte | output | 8 | Forwarded data byte |
| txb_load | input | 1 | Host transmit buffer holds data |
| txb_len | input | IDX_W | Number of bytes in the host buffer |
| txb_idx | output | IDX_W | Index of the buffer byte being read |
| txb_rdata | input | 8 | Buffer byte at `txb_idx` |
| txb_release | output | 1 | Last buffer byte accepted, buffer free |
| end_cmd | input | 1 | Host end-of-command pulse |

## Verification
The null keepalive and the host's procedure byte both compete for the single transmit slot, and they can fall due in the same cycle. The bench provokes this by counting cycles from the header pulse and raising `pb_valid` on exactly the edge where half the waiting time runs out. It holds `tx_ready` low at the same time. The result is judged by the transmitted byte: the scoreboard expects the procedure byte first with no 0x60 ahead of it. The byte must also stay stable while it is held back.

// File: rtl/t0_pkg.sv
package t0_pkg;
  // Header states carry the byte index in their encoding (0..4).
  typedef enum logic [2:0] {
    ST_CLA = 3'd0,
    ST_INS = 3'd1,
    ST_P1  = 3'd2,
    ST_P2  = 3'd3,
    ST_P3  = 3'd4,
    ST_PB  = 3'd5,
    ST_RXD = 3'd6,
    ST_TXD = 3'd7
  } t0_state_e;

  typedef enum logic [1:0] {
    TK_NULL = 2'd0,
    TK_PB   = 2'd1,
    TK_DAT  = 2'd2
  } tx_kind_e;

  localparam logic [7:0] NULL_PB   = 8'h60;
  localparam int         HDR_BYTES = 5;
endpackage

// File: rtl/t0_hdr_capture.sv
module t0_hdr_capture
  import t0_pkg::*;
#(
  parameter int NB = HDR_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [2:0]      cap_sel,
  input  logic [7:0]      cap_byte,
  output logic [8*NB-1:0] hdr_out
);
  for (genvar i = 0; i < NB; i++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (cap_en && (cap_sel == 3'(i))) q <= cap_byte;
    end
    assign hdr_out[8*(NB-1-i) +: 8] = q;
  end
endmodule

// File: rtl/t0_half_timer.sv
module t0_half_timer #(
  parameter int WT_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [WT_W-1:0] wait_clks,
  output logic            due
);
  logic [WT_W-1:0] half, lim, cnt_q, cnt_d;

  always_comb begin
    half = wait_clks >> 1;
    lim  = (half == '0) ? '0 : half - 1'b1;
    due  = run && (cnt_q >= lim);
    if (restart || !run || due) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/t0_tx_feed.sv
module t0_tx_feed
  import t0_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_pb,
  input  logic             in_txd,
  input  logic             null_due,
  input  logic             pb_valid,
  input  logic [7:0]       pb_byte,
  output logic             pb_ready,
  input  logic             txb_load,
  input  logic [IDX_W-1:0] txb_len,
  input  logic [7:0]       txb_rdata,
  output logic [IDX_W-1:0] txb_idx,
  output logic             txb_release,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             tx_accept,
  output logic             pb_sent
);
  logic             vld_q, vld_d;
  logic [7:0]       byte_q, byte_d;
  tx_kind_e         kind_q, kind_d;
  logic             act_q, act_d;
  logic [IDX_W-1:0] len_q, len_d, idx_q, idx_d, idx_nx;
  logic             slot_free, take_pb, take_null, take_dat, dat_sent, last;

  always_comb begin
    slot_free   = !vld_q;
    pb_ready    = in_pb && slot_free && !flush;
    take_pb     = pb_ready && pb_valid;
    take_null   = in_pb && slot_free && null_due && !pb_valid && !flush;
    take_dat    = in_txd && slot_free && act_q && !flush;
    tx_accept   = vld_q && tx_ready;
    pb_sent     = tx_accept && (kind_q == TK_PB);
    dat_sent    = tx_accept && (kind_q == TK_DAT);
    idx_nx      = idx_q + 1'b1;
    last        = (idx_nx == len_q);
    txb_release = dat_sent && last && !flush;

    vld_d  = vld_q;
    byte_d = byte_q;
    kind_d = kind_q;
    if (flush || tx_accept) begin
      vld_d = 1'b0;
    end else if (take_pb) begin
      vld_d = 1'b1; byte_d = pb_byte;   kind_d = TK_PB;
    end else if (take_null) begin
      vld_d = 1'b1; byte_d = NULL_PB;   kind_d = TK_NULL;
    end else if (take_dat) begin
      vld_d = 1'b1; byte_d = txb_rdata; kind_d = TK_DAT;
    end

    act_d = act_q;
    len_d = len_q;
    idx_d = idx_q;
    if (flush) begin
      act_d = 1'b0; idx_d = '0;
    end else if (dat_sent) begin
      if (last) begin act_d = 1'b0; idx_d = '0; end
      else      idx_d = idx_nx;
    end else if (txb_load && !act_q && (txb_len != '0)) begin
      act_d = 1'b1; len_d = txb_len; idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
      kind_q <= TK_NULL;
      act_q  <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      byte_q <= byte_d;
      kind_q <= kind_d;
      act_q  <= act_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
    end
  end

  assign tx_valid = vld_q;
  assign tx_byte  = byte_q;
  assign txb_idx  = idx_q;
endmodule

// File: rtl/t0_cmd_engine.sv
module t0_cmd_engine
  import t0_pkg::*;
#(
  parameter int WT_W  = 20,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WT_W-1:0]  wait_clks,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             rx_en,
  output logic             tx_en,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             tx_ready,
  output logic             hdr_valid,
  output logic [39:0]      hdr_data,
  input  logic             pb_valid,
  input  logic [7:0]       pb_byte,
  input  logic             pb_dir,
  output logic             pb_ready,
  output logic             rx_fwd_valid,
  output logic [7:0]       rx_fwd_byte,
  input  logic             txb_load,
  input  logic [IDX_W-1:0] txb_len,
  output logic [IDX_W-1:0] txb_idx,
  input  logic [7:0]       txb_rdata,
  output logic             txb_release,
  input  logic             end_cmd
);
  localparam int HDR_W = 8 * HDR_BYTES;

  t0_state_e  state_q, state_d;
  logic       dir_q, dir_d;
  logic       hdr_v_q, fwd_v_q;
  logic [7:0] fwd_b_q;
  logic       hdr_phase, rx_take, cap_en, in_pb, in_txd;
  logic       null_due, tx_accept, pb_sent, run_tmr;
  logic [HDR_W-1:0] hdr_w;

  always_comb begin
    hdr_phase = (state_q <= ST_P3);
    rx_en     = hdr_phase || (state_q == ST_RXD);
    tx_en     = (state_q == ST_PB) || (state_q == ST_TXD);
    rx_take   = rx_valid && rx_en;
    cap_en    = rx_take && hdr_phase && !end_cmd;
    in_pb     = (state_q == ST_PB);
    in_txd    = (state_q == ST_TXD);
    run_tmr   = in_pb && !tx_valid;

    state_d = state_q;
    dir_d   = dir_q;
    if (pb_valid && pb_ready) dir_d = pb_dir;
    if (end_cmd) begin
      state_d = ST_CLA;
    end else if (hdr_phase) begin
      if (rx_take) state_d = t0_state_e'(state_q + 3'd1);
    end else if (in_pb && pb_sent) begin
      state_d = dir_q ? ST_TXD : ST_RXD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLA;
      dir_q   <= 1'b0;
      hdr_v_q <= 1'b0;
      fwd_v_q <= 1'b0;
      fwd_b_q <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      hdr_v_q <= cap_en && (state_q == ST_P3);
      fwd_v_q <= rx_take && (state_q == ST_RXD) && !end_cmd;
      if (rx_take && (state_q == ST_RXD)) fwd_b_q <= rx_byte;
    end
  end

  t0_hdr_capture #(.NB(HDR_BYTES)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_sel(state_q),
    .cap_byte(rx_byte), .hdr_out(hdr_w)
  );

  t0_half_timer #(.WT_W(WT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run_tmr), .restart(rx_take || tx_accept),
    .wait_clks(wait_clks), .due(null_due)
  );

  t0_tx_feed #(.IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(end_cmd), .in_pb(in_pb), .in_txd(in_txd),
    .null_due(null_due), .pb_valid(pb_valid), .pb_byte(pb_byte),
    .pb_ready(pb_ready), .txb_load(txb_load), .txb_len(txb_len),
    .txb_rdata(txb_rdata), .txb_idx(txb_idx), .txb_release(txb_release),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_accept(tx_accept), .pb_sent(pb_sent)
  );

  assign hdr_valid    = hdr_v_q;
  assign hdr_data     = hdr_w;
  assign rx_fwd_valid = fwd_v_q;
  assign rx_fwd_byte  = fwd_b_q;
endmodule

// File: rtl/t0_cmd_engine_chk.sv
module t0_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_en,
  input logic       tx_en,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       tx_ready,
  input logic       hdr_valid,
  input logic       rx_fwd_valid,
  input logic       txb_release,
  input logic       end_cmd
);
  a_r3_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && tx_en));

  a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (tx_en && !rx_en));

  a_r2_hdr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  a_r6_fwd_origin: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fwd_valid |-> $past(rx_valid && rx_en));

  a_r7_release_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    txb_release |-> (tx_valid && tx_ready));

  a_r8_end_returns: assert property (@(posedge clk) disable iff (!rst_n)
    end_cmd |=> (rx_en && !tx_en && !tx_valid));

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !end_cmd) |=> (tx_valid && $stable(tx_byte)));
endmodule

bind t0_cmd_engine t0_cmd_engine_chk u_chk (.*);

// File: tb/sim_t0_cmd_engine.sv
module sim_t0_cmd_engine;
  localparam int WT_W = 20, IDX_W = 8, HALF = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, rx_valid, tx_ready, pb_valid, pb_dir, txb_load, end_cmd;
  logic [WT_W-1:0] wait_clks;
  logic [7:0] rx_byte, pb_byte;
  logic [IDX_W-1:0] txb_len;
  logic rx_en, tx_en, tx_valid, hdr_valid, pb_ready, rx_fwd_valid, txb_release;
  logic [7:0] tx_byte, rx_fwd_byte, txb_rdata;
  logic [39:0] hdr_data;
  logic [IDX_W-1:0] txb_idx;
  logic [7:0] bufm [0:15];

  assign txb_rdata = bufm[txb_idx[3:0]];

  t0_cmd_engine #(.WT_W(WT_W), .IDX_W(IDX_W)) u0 (.*);

  logic [7:0]  exp_tx[$];
  logic [7:0]  exp_rx[$];
  logic [39:0] exp_hdr[$];
  int n_chk = 0, n_fail = 0, cyc = 0, hdr_cyc = 0, tx_cnt = 0, rel_cnt = 0, fwd_cnt = 0;
  bit null_time_chk = 0, prev_txv = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (hdr_valid) begin
        hdr_cyc = cyc;
        if (exp_hdr.size() == 0) chk(0, "R2 unexpected header", hdr_data, 0);
        else begin
          logic [39:0] e;
          e = exp_hdr.pop_front();
          chk(hdr_data == e, "R2/R9 header record", hdr_data, e);
        end
      end
      if (tx_valid && !prev_txv && null_time_chk) begin
        chk(cyc - hdr_cyc == HALF, "R4 null delay", cyc - hdr_cyc, HALF);
        null_time_chk = 0;
      end
      prev_txv = tx_valid;
      if (tx_valid && tx_ready) begin
        tx_cnt++;
        if (exp_tx.size() == 0) chk(0, "R4/R5/R7 unexpected tx", tx_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          chk(tx_byte == e, "R4/R5/R7 tx byte", tx_byte, e);
        end
      end
      if (txb_release) begin
        rel_cnt++;
        chk(exp_tx.size() == 0, "R7 release with last byte", exp_tx.size(), 0);
      end
      if (rx_fwd_valid) begin
        fwd_cnt++;
        if (exp_rx.size() == 0) chk(0, "R6/R9 unexpected forward", rx_fwd_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(rx_fwd_byte == e, "R6 forwarded byte", rx_fwd_byte, e);
        end
      end
    end
  end

  task automatic send_rx(logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_hdr(logic [39:0] h);
    exp_hdr.push_back(h);
    for (int i = 4; i >= 0; i--) send_rx(h[8*i +: 8]);
  endtask

  task automatic wait_tx(int n);
    while (tx_cnt < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_end();
    @(negedge clk); end_cmd = 1'b1;
    @(negedge clk); end_cmd = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_byte = 0; tx_ready = 1; pb_valid = 0; pb_byte = 0;
    pb_dir = 0; txb_load = 0; txb_len = 0; end_cmd = 0; wait_clks = 20;
    for (int i = 0; i < 16; i++) bufm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rx_en && !tx_en, "R1 enables", {rx_en, tx_en}, 2'b10);
    chk(!tx_valid && !hdr_valid && !pb_ready, "R1 idle outputs",
        {tx_valid, hdr_valid, pb_ready}, 0);

    // Test A: nulls, then receive-data phase
    null_time_chk = 1;
    exp_tx.push_back(8'h60); exp_tx.push_back(8'h60);
    send_hdr(40'h00A4040002);
    chk(!rx_en && tx_en, "R3 turnaround", {rx_en, tx_en}, 2'b01);
    wait_tx(2);
    chk(tx_cnt == 2, "R4 repeated nulls", tx_cnt, 2);
    chk(pb_ready, "R5 pb_ready while waiting", pb_ready, 1);
    exp_tx.push_back(8'hA4);
    pb_valid = 1; pb_byte = 8'hA4; pb_dir = 0;
    @(negedge clk); pb_valid = 0;
    wait_tx(3);
    chk(rx_en && !tx_en, "R5/R6 receive phase", {rx_en, tx_en}, 2'b10);
    exp_rx.push_back(8'h11); exp_rx.push_back(8'h22); exp_rx.push_back(8'h33);
    send_rx(8'h11); send_rx(8'h22); send_rx(8'h33);
    @(negedge clk);
    chk(fwd_cnt == 3, "R6 forward count", fwd_cnt, 3);
    chk(rx_en, "R6 stays in receive", rx_en, 1);
    pulse_end();
    chk(rx_en && !tx_en && !tx_valid, "R8 back to header", {rx_en, tx_en, tx_valid}, 3'b100);

    // Test B: procedure byte collides with due null; transmit-data phase
    tx_ready = 0;
    send_hdr(40'h80CA9F7F04);
    repeat (HALF - 1) @(posedge clk);
    @(negedge clk);
    pb_valid = 1; pb_byte = 8'hCA; pb_dir = 1;
    exp_tx.push_back(8'hCA);
    @(negedge clk); pb_valid = 0;
    chk(tx_valid && tx_byte == 8'hCA, "R5 procedure byte wins", tx_byte, 8'hCA);
    repeat (4) @(negedge clk);
    chk(tx_valid && tx_byte == 8'hCA, "R10 byte held", tx_byte, 8'hCA);
    tx_ready = 1;
    wait_tx(4);
    chk(tx_en && !rx_en, "R5 transmit phase", {rx_en, tx_en}, 2'b01);
    send_rx(8'h5A); // R9 stray byte while receiver disabled
    @(negedge clk);
    chk(fwd_cnt == 3, "R9 stray not forwarded", fwd_cnt, 3);
    bufm[0] = 8'hDE; bufm[1] = 8'hAD; bufm[2] = 8'hBE; bufm[3] = 8'hEF;
    exp_tx.push_back(8'hDE); exp_tx.push_back(8'hAD);
    exp_tx.push_back(8'hBE); exp_tx.push_back(8'hEF);
    txb_len = 4; txb_load = 1;
    @(negedge clk); txb_load = 0;
    wait_tx(8);
    repeat (3) @(negedge clk);
    chk(rel_cnt == 1, "R7 release count", rel_cnt, 1);
    chk(tx_cnt == 8 && !tx_valid, "R7 nothing after buffer", tx_cnt, 8);
    chk(tx_en, "R7 stays in transmit", tx_en, 1);
    pulse_end();

    // Test C: stray byte not captured; end from wait-for-procedure
    send_hdr(40'h0102030405);
    pulse_end();
    chk(rx_en && !tx_en && !tx_valid, "R8 end from waiting", {rx_en, tx_en, tx_valid}, 3'b100);
    repeat (2 * HALF) @(negedge clk);
    chk(tx_cnt == 8, "R8 no null after end", tx_cnt, 8);

    chk(exp_tx.size() == 0 && exp_rx.size() == 0 && exp_hdr.size() == 0,
        "R2/R6/R7 scoreboard drained", exp_tx.size() + exp_rx.size() + exp_hdr.size(), 0);
    summary();
    $finish;
  end
endmodule